// File: doc/BRIEF.md
# Reset and Boot Mode Controller

This block supervises the reset line and the mode-select pins of an attached microcontroller. After power is applied, or whenever the asynchronous power-on indication is asserted, it holds the device in reset for a programmable number of clock cycles and then lets it run in user mode. A reset button restarts that timed reset. A boot button or a serial clear-to-send style request, taken only while the device is running, starts a boot reset instead. During a boot reset the controller enables its mode outputs and drives a fixed boot value on them, so that the device samples boot mode when reset is released.

The reset period is retriggerable. Holding the reset button, the boot button or the serial request during any reset keeps the timer reloaded. The full period therefore counts from the last cycle any of them was seen active. The buttons and the serial request pass through two-flop synchronizers. A separate NMI button is debounced and gives one single-cycle NMI pulse per qualified press, but only while the device runs in user mode.

The controller uses four states: user reset, user running, boot reset and boot running. The timer length, the debounce length, the width of the mode bus and the boot value are parameters. A bench can therefore shorten the timing from its default of about 500 ms at 125 MHz.

Top module: `rst_boot_ctrl`

## Requirements
- R1: While `por_n` is low, `dev_rst_n` is 0, `mode_oe` is 0 and `nmi_pulse` is 0. After `por_n` rises with no button active, `dev_rst_n` stays 0 for RST_CYCLES+2 sampled cycles and rises on the (RST_CYCLES+3)th rising clock edge. The controller is then in the user running state.
- R2: `rst_btn`, `boot_btn`, `cts_req` and `nmi_btn` are active high, and each passes through a two-flop synchronizer. A reset press applied between edges pulls `dev_rst_n` low on the third rising edge after it.
- R3: Any of `rst_btn`, `boot_btn` or `cts_req` active during a reset reloads the timer. With one reset press held for H cycles, `dev_rst_n` is low for H+RST_CYCLES sampled cycles.
- R4: From either running state, a reset press enters user reset: `dev_rst_n` is 0 and `mode_oe` is 0.
- R5: From user running, a boot press or a `cts_req` enters boot reset: `dev_rst_n` is 0, `mode_oe` is 1, and `mode_out` equals BOOT_MODE (default all zeros).
- R6: A boot press made while a reset is in progress never enables `mode_oe`. The controller leaves that reset into user running.
- R7: If reset and boot are both requested in a running state, reset wins: the controller enters user reset.
- R8: When a boot reset expires, the controller enters boot running: `dev_rst_n` is 1 and `mode_oe` is 0. Outside boot reset, `mode_oe` is 0 and `mode_out` is 0.
- R9: From boot running, a reset press enters user reset, and a boot press or `cts_req` enters a new boot reset.
- R10: An NMI press stable for DEB_CYCLES synchronized cycles produces exactly one single-cycle `nmi_pulse`. A shorter glitch produces none. A long hold produces no further pulse until a qualified release.
- R11: `nmi_pulse` is produced only from the user running state. A press qualified during a reset or in boot running is dropped and is not replayed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on / reset indication, active low |
| rst_btn | input | 1 | Reset button, active high, asynchronous |
| boot_btn | input | 1 | Boot button, active high, asynchronous |
| cts_req | input | 1 | Serial boot request, active high, asynchronous |
| nmi_btn | input | 1 | NMI button, active high, raw (bouncing) |
| dev_rst_n | output | 1 | Reset to the device, active low |
| mode_out | output | MODE_W | Mode pin values, valid when `mode_oe` is 1 |
| mode_oe | output | 1 | Output enable for the mode pins (0 = high impedance) |
| nmi_pulse | output | 1 | Single-cycle NMI pulse to the device |

## Verification
The bench targets a boot press made in the middle of a reset. A design that latched it would raise `mode_oe` and start the device in boot mode. It also holds the reset button for a long time, where a timer that is not retriggered would release reset early. Presses of reset and boot in the same cycle expose a priority inversion that enters boot reset. On the NMI path, a short glitch, a long hold, a press in boot running and a press spanning a reset would each give a spurious or repeated pulse if the stability count, the release qualification or the state gating were wrong. Exact release edges after power-up and after a press pin down off-by-one errors in the synchronizers and the timer.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {
    ST_USR_RST  = 2'd0,
    ST_USR_RUN  = 2'd1,
    ST_BOOT_RST = 2'd2,
    ST_BOOT_RUN = 2'd3
  } rbc_state_e;

  typedef struct packed {
    logic nmi;
    logic cts;
    logic boot;
    logic rst;
  } rbc_req_t;

  localparam int REQ_W = $bits(rbc_req_t);

endpackage

// File: rtl/rbc_sync.sv
module rbc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/rbc_timer.sv
module rbc_timer #(
  parameter int CYCLES = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);

  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = TW'(CYCLES);
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TW'(CYCLES);
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rbc_fsm.sv
module rbc_fsm
  import rbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_rst,
  input  logic       req_boot,
  input  logic       req_cts,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output rbc_state_e state
);

  rbc_state_e state_d;
  logic       hold;

  assign hold = req_rst || req_boot || req_cts;

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    unique case (state)
      ST_USR_RST, ST_BOOT_RST: begin
        if (hold) begin
          tmr_load = 1'b1;
        end else if (tmr_zero) begin
          state_d = (state == ST_USR_RST) ? ST_USR_RUN : ST_BOOT_RUN;
        end
      end
      ST_USR_RUN, ST_BOOT_RUN: begin
        if (req_rst) begin
          state_d  = ST_USR_RST;
          tmr_load = 1'b1;
        end else if (req_boot || req_cts) begin
          state_d  = ST_BOOT_RST;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_USR_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_USR_RST;
    else        state <= state_d;
  end

endmodule

// File: rtl/rbc_debounce.sv
module rbc_debounce #(
  parameter int STABLE = 1_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic press
);

  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic          level_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ, done, level_en;

  assign differ   = (din != level_q);
  assign done     = differ && (cnt_q == CW'(STABLE - 1));
  assign level_en = done;
  assign press    = done && din;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!differ || done) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (level_en) level_q <= din;
    end
  end

endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
  import rbc_pkg::*;
#(
  parameter int                RST_CYCLES = 62_500_000,
  parameter int                DEB_CYCLES = 1_250_000,
  parameter int                MODE_W     = 3,
  parameter logic [MODE_W-1:0] BOOT_MODE  = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_btn,
  input  logic              boot_btn,
  input  logic              cts_req,
  input  logic              nmi_btn,
  output logic              dev_rst_n,
  output logic [MODE_W-1:0] mode_out,
  output logic              mode_oe,
  output logic              nmi_pulse
);

  localparam int SYNC_STAGES = 2;

  // power-on reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] por_q;
  logic                   arst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_q <= '0;
    else        por_q <= {por_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign arst_n = por_q[SYNC_STAGES-1];

  rbc_req_t req_raw, req_s;
  assign req_raw = '{nmi: nmi_btn, cts: cts_req, boot: boot_btn, rst: rst_btn};

  rbc_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (req_raw),
    .q     (req_s)
  );

  logic       tmr_load, tmr_zero;
  rbc_state_e state;

  rbc_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (arst_n),
    .load  (tmr_load),
    .zero  (tmr_zero)
  );

  rbc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (arst_n),
    .req_rst  (req_s.rst),
    .req_boot (req_s.boot),
    .req_cts  (req_s.cts),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .state    (state)
  );

  logic nmi_press;

  rbc_debounce #(.STABLE(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (arst_n),
    .din   (req_s.nmi),
    .press (nmi_press)
  );

  logic nmi_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) nmi_q <= 1'b0;
    else         nmi_q <= nmi_press && (state == ST_USR_RUN);
  end

  assign dev_rst_n = !((state == ST_USR_RST) || (state == ST_BOOT_RST));
  assign mode_oe   = (state == ST_BOOT_RST);
  assign mode_out  = mode_oe ? BOOT_MODE : '0;
  assign nmi_pulse = nmi_q;

endmodule

// File: rtl/rbc_checks.sv
module rbc_checks (
  input logic clk,
  input logic rst_n,
  input logic dev_rst_n,
  input logic mode_oe,
  input logic nmi_pulse,
  input logic tmr_zero
);

  a_r5_oe_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oe |-> !dev_rst_n);

  a_r6_boot_from_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_oe) |-> $past(dev_rst_n));

  a_r8_boot_exit_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_oe) |-> dev_rst_n);

  a_r3_release_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> $past(tmr_zero));

  a_r10_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);

  a_r11_nmi_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> $past(dev_rst_n));

endmodule

bind rst_boot_ctrl rbc_checks u_chk (
  .clk       (clk),
  .rst_n     (arst_n),
  .dev_rst_n (dev_rst_n),
  .mode_oe   (mode_oe),
  .nmi_pulse (nmi_pulse),
  .tmr_zero  (tmr_zero)
);

// File: tb/tb_rst_boot_ctrl.sv
`timescale 1ns/1ps
module tb_rst_boot_ctrl;

  localparam int R  = 20;
  localparam int D  = 4;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic por_n, rst_btn, boot_btn, cts_req, nmi_btn;
  logic dev_rst_n, mode_oe, nmi_pulse;
  logic [MW-1:0] mode_out;

  always #4 clk = ~clk;

  rst_boot_ctrl #(.RST_CYCLES(R), .DEB_CYCLES(D), .MODE_W(MW), .BOOT_MODE('0)) dut (
    .clk(clk), .por_n(por_n), .rst_btn(rst_btn), .boot_btn(boot_btn),
    .cts_req(cts_req), .nmi_btn(nmi_btn), .dev_rst_n(dev_rst_n),
    .mode_out(mode_out), .mode_oe(mode_oe), .nmi_pulse(nmi_pulse)
  );

  int    total = 0, bad = 0, cyc = 0, npulse = 0;
  string cur_tag = "R1";
  bit    finished = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_rel, mst, tcnt, dcnt;
  bit  lvl, pulse;
  bit [1:0] sr, sb, sc, sn;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rel = 0; mst = 0; tcnt = R; dcnt = 0; lvl = 0; pulse = 0;
      sr = 0; sb = 0; sc = 0; sn = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit hold, load, rise;
      int nst, ntc;
      hold = sr[1] | sb[1] | sc[1];
      load = 0; nst = mst; rise = 0;
      if (mst == 0 || mst == 2) begin
        if (hold) load = 1;
        else if (tcnt == 0) nst = mst + 1;
      end else if (sr[1]) begin
        nst = 0; load = 1;
      end else if (sb[1] | sc[1]) begin
        nst = 2; load = 1;
      end
      ntc = load ? R : (tcnt > 0 ? tcnt - 1 : 0);
      if (sn[1] == lvl) dcnt = 0;
      else if (dcnt == D - 1) begin lvl = sn[1]; dcnt = 0; rise = lvl; end
      else dcnt++;
      pulse = rise && (mst == 1);
      mst = nst; tcnt = ntc;
      sr = {sr[0], rst_btn}; sb = {sb[0], boot_btn};
      sc = {sc[0], cts_req}; sn = {sn[0], nmi_btn};
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      int exp_v, act_v;
      exp_v = {(mst == 0 || mst == 2) ? 1'b0 : 1'b1, (mst == 2), 3'b000, pulse};
      act_v = {dev_rst_n, mode_oe, mode_out, nmi_pulse};
      chk(cur_tag, act_v, exp_v);
      if (nmi_pulse) npulse++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_high();
    for (int i = 0; i < 1000; i++) begin
      if (dev_rst_n) break;
      step(1);
    end
  endtask

  task automatic press(ref logic sig, input int n);
    @(negedge clk); sig = 1'b1;
    step(n);
    @(negedge clk); sig = 1'b0;
    #1;
  endtask

  initial begin
    int low, oes, p0;
    por_n = 0; rst_btn = 0; boot_btn = 0; cts_req = 0; nmi_btn = 0;
    step(5);
    chk("R1", dev_rst_n, 0); chk("R1", mode_oe, 0); chk("R1", nmi_pulse, 0);

    @(negedge clk); por_n = 1;
    low = 0;
    for (int i = 0; i < 200; i++) begin step(1); if (dev_rst_n) break; low++; end
    chk("R1", low, R + 2);

    cur_tag = "R10"; step(5);
    p0 = npulse; press(nmi_btn, 10); step(10); chk("R10", npulse - p0, 1);
    p0 = npulse; press(nmi_btn, 2);  step(10); chk("R10", npulse - p0, 0);
    p0 = npulse; press(nmi_btn, 30); step(10); chk("R10", npulse - p0, 1);

    cur_tag = "R2";
    @(negedge clk); rst_btn = 1; #1;
    step(1); chk("R2", dev_rst_n, 1);
    step(1); chk("R2", dev_rst_n, 1);
    step(1); chk("R2", dev_rst_n, 0); chk("R4", mode_oe, 0);
    @(negedge clk); rst_btn = 0;
    cur_tag = "R6"; step(4);
    oes = 0;
    @(negedge clk); boot_btn = 1;
    step(3);
    @(negedge clk); boot_btn = 0;
    for (int i = 0; i < 200; i++) begin step(1); if (mode_oe) oes++; if (dev_rst_n) break; end
    chk("R6", oes, 0); step(5); chk("R6", mode_oe, 0); chk("R6", dev_rst_n, 1);

    cur_tag = "R3";
    @(negedge clk); rst_btn = 1;
    low = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (i == 29) rst_btn = 0;
      if (!dev_rst_n) low++;
      else if (low > 0) break;
    end
    chk("R3", low, 30 + R);

    cur_tag = "R11";
    @(negedge clk); rst_btn = 1; step(2); @(negedge clk); rst_btn = 0;
    p0 = npulse; press(nmi_btn, 10);
    wait_high(); step(5); chk("R11", npulse - p0, 0);
    @(negedge clk); nmi_btn = 0; step(10);

    cur_tag = "R5";
    press(boot_btn, 2); step(1);
    chk("R5", mode_oe, 1); chk("R5", dev_rst_n, 0); chk("R5", mode_out, 0);
    cur_tag = "R8"; wait_high(); step(1);
    chk("R8", dev_rst_n, 1); chk("R8", mode_oe, 0); chk("R8", mode_out, 0);
    cur_tag = "R11"; p0 = npulse; press(nmi_btn, 10); step(10); chk("R11", npulse - p0, 0);

    cur_tag = "R9";
    press(cts_req, 2); step(1); chk("R9", mode_oe, 1);
    wait_high(); step(2);
    press(rst_btn, 2); step(1); chk("R9", dev_rst_n, 0); chk("R9", mode_oe, 0);
    wait_high(); step(2);
    cur_tag = "R5";
    press(cts_req, 2); step(1); chk("R5", mode_oe, 1);
    wait_high(); step(2);
    cur_tag = "R9";
    press(boot_btn, 2); step(1); chk("R9", mode_oe, 1);
    wait_high(); step(2);
    press(rst_btn, 2); wait_high(); step(2);

    cur_tag = "R7";
    @(negedge clk); rst_btn = 1; boot_btn = 1;
    step(2); @(negedge clk); rst_btn = 0; boot_btn = 0; #1;
    step(1); chk("R7", dev_rst_n, 0); chk("R7", mode_oe, 0);
    wait_high(); step(5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule